// File: doc/BRIEF.md
# Address/Command Rate Converter

This block sits between a memory controller and the memory pins. It re-times address, bank and command fields (row strobe, column strobe, write enable) plus chip select, clock enable and termination control onto the memory clock. An elaboration parameter chooses one of two operating modes.

In full-rate mode every field is registered once per memory cycle (1T). In half-rate mode the controller presents a new address/command word once per two memory cycles. The block marks the sampling cycle with `load_o`. It holds the address, bank and command fields for both cycles of that window (2T). Chip select, clock enable and termination take a separate value in each of the two memory cycles (1T): slot 0 is driven in the first cycle and slot 1 in the second.

Chip select is active low and belongs to the command code. A high chip select masks the command at the memory, so a window with both chip-select slots high issues nothing.

Top module: `ac_rate_conv`

## Requirements
- R1: While rst_ni is low, the outputs are: mem_cs_n_o=1, mem_cke_o=0, mem_odt_o=0, ras/cas/we all 1 (NOP), mem_addr_o=0, mem_bank_o=0. In half-rate mode load_o is also 1 while rst_ni is low.
- R2: Full-rate mode (HALF_RATE=0): every output equals the value of its input one clock earlier. cs/cke/odt take bit 0 of their 2-bit inputs, bit 1 is ignored, and load_o is constantly 1.
- R3: Half-rate mode: load_o is 1 in the first cycle after reset and then alternates every cycle. A new address/command word is therefore accepted at most every two memory cycles.
- R4: Half-rate mode: addr, bank, ras_n, cas_n and we_n are sampled at a clock edge only where load_o is 1. The sampled values are then held for two cycles (2T). Changes to these inputs while load_o is 0 have no effect on the outputs.
- R5: Half-rate mode: at a sampling edge, bit 0 of cs_n_i, cke_i and odt_i drives the first output cycle and bit 1 drives the second (1T each). The first cycle of each window coincides with the new address/command.
- R6: A window whose chip-select slots are both 1 keeps mem_cs_n_o high in both cycles, so the command fields are masked at the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory (full-rate) clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Address from controller |
| bank_i | input | BANK_W | Bank from controller |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| cs_n_i | input | 2 | Chip select per slot, bit 0 first |
| cke_i | input | 2 | Clock enable per slot, bit 0 first |
| odt_i | input | 2 | Termination per slot, bit 0 first |
| load_o | output | 1 | Inputs sampled at the next edge |
| mem_addr_o | output | ADDR_W | Address to memory |
| mem_bank_o | output | BANK_W | Bank to memory |
| mem_ras_n_o | output | 1 | Row strobe to memory |
| mem_cas_n_o | output | 1 | Column strobe to memory |
| mem_we_n_o | output | 1 | Write enable to memory |
| mem_cs_n_o | output | 1 | Chip select to memory |
| mem_cke_o | output | 1 | Clock enable to memory |
| mem_odt_o | output | 1 | Termination to memory |

## Verification
The assertions assume that the controller follows `load_o` and keeps its inputs stable around each rising edge. The 2T stability check relates only outputs and the phase, so it holds whatever the inputs do between sampling edges. The bench changes every input on each falling edge, including cycles in which `load_o` is 0, to show that off-phase changes have no effect. Every seventh word forces both chip-select slots high to exercise masking. A second instance in full-rate mode receives the same stimulus.

// File: rtl/ac_pkg.sv
package ac_pkg;
  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
  } ac_cmd_t;

  localparam ac_cmd_t CMD_NOP = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
endpackage

// File: rtl/ac_phase_gen.sv
module ac_phase_gen #(
  parameter bit HALF_RATE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic load_o
);
  if (HALF_RATE) begin : g_half
    logic odd_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) odd_q <= 1'b0;
      else         odd_q <= ~odd_q;
    end
    assign load_o = ~odd_q;

    // R3: no two sampling edges back to back
    assert_load_rate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_o |=> !load_o);
  end else begin : g_full
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign load_o = 1'b1;
  end
endmodule

// File: rtl/ac_hold_reg.sv
module ac_hold_reg #(
  parameter int          W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/ac_slot_ser.sv
module ac_slot_ser #(
  parameter bit   HALF_RATE = 1'b1,
  parameter logic RST_VAL   = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [1:0] slot_i,
  output logic       q_o
);
  if (HALF_RATE) begin : g_half
    logic second_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q_o      <= RST_VAL;
        second_q <= RST_VAL;
      end else if (load_i) begin
        q_o      <= slot_i[0];
        second_q <= slot_i[1];
      end else begin
        q_o      <= second_q;
      end
    end

    // R5: second cycle of a window carries slot 1 from the sampling edge
    assert_slot1_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(!load_i) |-> q_o == $past(slot_i[1], 2));
  end else begin : g_full
    logic unused_slot;
    assign unused_slot = slot_i[1] ^ load_i;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= RST_VAL;
      else         q_o <= slot_i[0];
    end
  end
endmodule

// File: rtl/ac_rate_conv.sv
module ac_rate_conv
  import ac_pkg::*;
#(
  parameter bit HALF_RATE = 1'b1,
  parameter int ADDR_W    = 13,
  parameter int BANK_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              ras_n_i,
  input  logic              cas_n_i,
  input  logic              we_n_i,
  input  logic [1:0]        cs_n_i,
  input  logic [1:0]        cke_i,
  input  logic [1:0]        odt_i,
  output logic              load_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BANK_W-1:0] mem_bank_o,
  output logic              mem_ras_n_o,
  output logic              mem_cas_n_o,
  output logic              mem_we_n_o,
  output logic              mem_cs_n_o,
  output logic              mem_cke_o,
  output logic              mem_odt_o
);
  localparam int CMD_W = $bits(ac_cmd_t);
  localparam int WORD_W = ADDR_W + BANK_W + CMD_W;
  localparam logic [WORD_W-1:0] WORD_RST = {{ADDR_W{1'b0}}, {BANK_W{1'b0}}, CMD_NOP};

  ac_cmd_t          cmd_in;
  logic [WORD_W-1:0] word_d, word_q;
  ac_cmd_t          cmd_q;

  assign cmd_in = '{ras_n: ras_n_i, cas_n: cas_n_i, we_n: we_n_i};
  assign word_d = {addr_i, bank_i, cmd_in};

  ac_phase_gen #(.HALF_RATE(HALF_RATE)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_o (load_o)
  );

  // 2T (half rate) or 1T (full rate) path for address, bank and command
  ac_hold_reg #(.W(WORD_W), .RST_VAL(WORD_RST)) u_word (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (load_o),
    .d_i    (word_d),
    .q_o    (word_q)
  );

  assign {mem_addr_o, mem_bank_o, cmd_q} = word_q;
  assign mem_ras_n_o = cmd_q.ras_n;
  assign mem_cas_n_o = cmd_q.cas_n;
  assign mem_we_n_o  = cmd_q.we_n;

  // 1T path for chip select, clock enable and termination
  ac_slot_ser #(.HALF_RATE(HALF_RATE), .RST_VAL(1'b1)) u_cs (
    .clk_i (clk_i), .rst_ni (rst_ni), .load_i (load_o), .slot_i (cs_n_i), .q_o (mem_cs_n_o)
  );
  ac_slot_ser #(.HALF_RATE(HALF_RATE), .RST_VAL(1'b0)) u_cke (
    .clk_i (clk_i), .rst_ni (rst_ni), .load_i (load_o), .slot_i (cke_i), .q_o (mem_cke_o)
  );
  ac_slot_ser #(.HALF_RATE(HALF_RATE), .RST_VAL(1'b0)) u_odt (
    .clk_i (clk_i), .rst_ni (rst_ni), .load_i (load_o), .slot_i (odt_i), .q_o (mem_odt_o)
  );

  if (HALF_RATE) begin : g_chk_half
    // R4: second cycle of a window leaves address/command untouched
    assert_word_2t_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_o |=> $stable({mem_addr_o, mem_bank_o, mem_ras_n_o, mem_cas_n_o, mem_we_n_o}));
  end else begin : g_chk_full
    // R2: one-cycle latency on every field
    assert_full_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (mem_addr_o == $past(addr_i)) && (mem_cs_n_o == $past(cs_n_i[0]))
               && (mem_we_n_o == $past(we_n_i)));
  end
endmodule

// File: tb/tb_ac_rate_conv.sv
module tb_ac_rate_conv;
  localparam int AW = 13;
  localparam int BW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [AW-1:0] addr;
  logic [BW-1:0] bank;
  logic ras_n, cas_n, we_n;
  logic [1:0] cs_n, cke, odt;

  logic h_load, h_ras, h_cas, h_we, h_cs, h_cke, h_odt;
  logic [AW-1:0] h_addr;
  logic [BW-1:0] h_bank;
  logic f_load, f_ras, f_cas, f_we, f_cs, f_cke, f_odt;
  logic [AW-1:0] f_addr;
  logic [BW-1:0] f_bank;

  ac_rate_conv #(.HALF_RATE(1'b1), .ADDR_W(AW), .BANK_W(BW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .bank_i(bank),
    .ras_n_i(ras_n), .cas_n_i(cas_n), .we_n_i(we_n),
    .cs_n_i(cs_n), .cke_i(cke), .odt_i(odt), .load_o(h_load),
    .mem_addr_o(h_addr), .mem_bank_o(h_bank), .mem_ras_n_o(h_ras),
    .mem_cas_n_o(h_cas), .mem_we_n_o(h_we), .mem_cs_n_o(h_cs),
    .mem_cke_o(h_cke), .mem_odt_o(h_odt));

  ac_rate_conv #(.HALF_RATE(1'b0), .ADDR_W(AW), .BANK_W(BW)) dut_fr (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .bank_i(bank),
    .ras_n_i(ras_n), .cas_n_i(cas_n), .we_n_i(we_n),
    .cs_n_i(cs_n), .cke_i(cke), .odt_i(odt), .load_o(f_load),
    .mem_addr_o(f_addr), .mem_bank_o(f_bank), .mem_ras_n_o(f_ras),
    .mem_cas_n_o(f_cas), .mem_we_n_o(f_we), .mem_cs_n_o(f_cs),
    .mem_cke_o(f_cke), .mem_odt_o(f_odt));

  int errors = 0;
  int checks = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int unsigned cyc;
  logic [AW+BW+2:0] m_word, f_word;
  logic m_cs, m_cke, m_odt, p_cs, p_cke, p_odt;
  logic e_cs, e_cke, e_odt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc = 0;
      m_word = {{AW{1'b0}}, {BW{1'b0}}, 3'b111};
      f_word = m_word;
      {m_cs, m_cke, m_odt} = 3'b100;
      {p_cs, p_cke, p_odt} = 3'b100;
      {e_cs, e_cke, e_odt} = 3'b100;
    end else begin
      if (cyc % 2 == 0) begin
        m_word = {addr, bank, ras_n, cas_n, we_n};
        {m_cs, m_cke, m_odt} = {cs_n[0], cke[0], odt[0]};
        {p_cs, p_cke, p_odt} = {cs_n[1], cke[1], odt[1]};
      end else begin
        {m_cs, m_cke, m_odt} = {p_cs, p_cke, p_odt};
      end
      f_word = {addr, bank, ras_n, cas_n, we_n};
      {e_cs, e_cke, e_odt} = {cs_n[0], cke[0], odt[0]};
      cyc++;
    end
  end

  task automatic drive_nop();
    addr = '0; bank = '0; {ras_n, cas_n, we_n} = 3'b111;
    cs_n = 2'b11; cke = 2'b00; odt = 2'b00;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    drive_nop();
    @(negedge clk);
    addr = 13'h1abc; cs_n = 2'b00; cke = 2'b11; odt = 2'b11;
    @(negedge clk);
    // R1 reset state on both instances
    chk("R1 half cs", h_cs, 1); chk("R1 half cke", h_cke, 0); chk("R1 half odt", h_odt, 0);
    chk("R1 half word", {h_addr, h_bank, h_ras, h_cas, h_we}, {{AW{1'b0}}, {BW{1'b0}}, 3'b111});
    chk("R1 half load", h_load, 1);
    chk("R1 full cs", f_cs, 1); chk("R1 full cke", f_cke, 0);
    chk("R1 full word", {f_addr, f_bank, f_ras, f_cas, f_we}, {{AW{1'b0}}, {BW{1'b0}}, 3'b111});
    drive_nop();
    rst_n = 1'b1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      chk("R3 load", h_load, (cyc % 2 == 0));
      chk("R4 word 2T", {h_addr, h_bank, h_ras, h_cas, h_we}, m_word);
      if (m_cs) chk("R6 masked cs", h_cs, m_cs);
      else      chk("R5 cs slot", h_cs, m_cs);
      chk("R5 cke slot", h_cke, m_cke);
      chk("R5 odt slot", h_odt, m_odt);
      chk("R2 full word", {f_addr, f_bank, f_ras, f_cas, f_we}, f_word);
      chk("R2 full cs/cke/odt", {f_cs, f_cke, f_odt}, {e_cs, e_cke, e_odt});
      chk("R2 full load", f_load, 1);
      addr = AW'($urandom);
      bank = BW'($urandom);
      {ras_n, cas_n, we_n} = 3'($urandom);
      cs_n = (i % 7 == 0) ? 2'b11 : 2'($urandom);
      cke  = 2'($urandom);
      odt  = 2'($urandom);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule